// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates one virtual address per request by descending a tree of in-memory directories. A request supplies the root directory base, the entry-count exponent of the root directory, the size exponent of the whole address space and the access kind (read, write, execute) with a user-mode flag. Every directory entry is 8 bytes wide. Each level consumes some address bits, fetches one entry through a 64-bit memory port whose latency is not fixed, and either descends further or stops on a leaf or a fault.

When it reaches a leaf, the walker checks the requested access against the entry's permission bits and forms the real address and page size. It then sets the referenced bit and, for writes, the changed bit. The entry goes back to memory only when these updates alter its value. The result appears as a one-cycle completion pulse that carries a fault code, the real address, the page size exponent and the granted permissions.

Entry layout. Bit 63 is valid and bit 62 is leaf. In a leaf, bits 55:12 are the page number, bit 8 is referenced, bit 7 is changed, bits 5:4 are the memory attribute (2'b11 marks non-idempotent I/O), bit 3 is privileged, and bits 2/1/0 allow read/write/execute. In a non-leaf entry, bits 55:8 give the next base (the low 8 bits are zero) and bits 4:0 give the next entry-count exponent. Access codes: 0 read, 1 write, 2 execute; 3 is handled as read. Fault codes: 0 none, 1 bad configuration, 2 missing entry, 3 protection, 4 guarded execute. Permission outputs use bit 2 read, bit 1 write, bit 0 execute.

Top module: `radix_walker`

## Requirements
- R1: After reset the block is idle: req_ready is 1, done is 0 and mem_req_valid is 0.
- R2: If the current level's entry-count exponent is below 5, or larger than the remaining size exponent, the walk ends with fault code 1 and that level issues no memory read.
- R3: Each level reads address base + 8 × ((vaddr >> (remaining − nls)) mod 2^nls). After each read, the remaining size exponent drops by nls.
- R4: An entry with bit 63 clear ends the walk with fault code 2.
- R5: A valid non-leaf entry makes {entry[55:8], 8'b0} the next base and entry[4:0] the next entry-count exponent.
- R6: A valid leaf ends the walk. The page size output equals the remaining exponent. The real address is ({entry[55:12],12'b0} with the bits below the remaining exponent cleared) ORed with those low bits of vaddr, truncated to PA_W bits.
- R7: An execute access to a leaf with attribute 2'b11 gives fault code 4. Otherwise the granted rights are zero for a user access to a privileged leaf, and entry[2:0] in every other case. A requested right that is not granted gives fault code 3.
- R8: On success the written-back entry has bit 8 set, and also bit 7 set for a write access. The granted permissions drop write for any non-write access.
- R9: On success the block writes the updated entry to the address it was read from, and only when the update changed the entry's value. A faulting walk writes nothing.
- R10: A walk makes at most MAX_LEVELS reads. A walk that would need more ends with fault code 1.
- R11: A memory request holds its valid, address and write flag until mem_req_ready. A read result is accepted on mem_rsp_valid any number of cycles later.
- R12: done is a single-cycle pulse. req_ready is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root_base | input | 64 | Byte address of the root directory |
| req_root_nls | input | 5 | Entry-count exponent of the root |
| req_space_bits | input | 6 | Size exponent of the address space |
| req_access | input | 2 | 0 read, 1 write, 2 execute |
| req_user | input | 1 | Access made in user mode |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_req_wdata | output | 64 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| done_fault | output | 3 | Fault code, 0 on success |
| done_paddr | output | PA_W | Real address |
| done_page_bits | output | 6 | Page size exponent |
| done_perm | output | 3 | Granted read/write/execute |

## Verification
A wrong remaining-size or base register makes the next read go to a different address. That either changes the entry fetched, and so the real address, the page size or the fault code of the same walk, or changes the number of reads counted before the done pulse. A wrong permission or update decision shows at the done pulse, or as a write-back that is missing, extra or carries the wrong data before that pulse. Sweeps through a two-level tree, a dense permission grid on a single leaf, and a self-referencing directory bring each of these effects out within the walk that causes them.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int MAX_LEVELS = 8,
  parameter int PA_W = 56
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [63:0]     req_root_base,
  input  logic [4:0]      req_root_nls,
  input  logic [5:0]      req_space_bits,
  input  logic [1:0]      req_access,
  input  logic            req_user,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [63:0]     mem_req_addr,
  output logic [63:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done,
  output logic [2:0]      done_fault,
  output logic [PA_W-1:0] done_paddr,
  output logic [5:0]      done_page_bits,
  output logic [2:0]      done_perm
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);
  localparam logic [2:0] F_NONE = 3'd0, F_CFG = 3'd1, F_NOPTE = 3'd2,
                         F_PROT = 3'd3, F_GUARD = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_LEVEL, S_READ, S_WAIT, S_EVAL, S_WB, S_FIN} st_t;
  st_t state;

  logic [63:0]     va_q, base_q, ent_addr_q, entry_q, wdata_q;
  logic [4:0]      nls_q;
  logic [5:0]      rem_q, page_q;
  logic [1:0]      acc_q;
  logic            user_q;
  logic [LVL_W-1:0] lvl_q;
  logic [2:0]      fault_q, perm_q;
  logic [PA_W-1:0] paddr_q;

  logic [5:0]  shamt;
  logic [63:0] idx, pmask, rpn, new_e;
  logic [PA_W-1:0] pa;
  logic        cfg_bad, guard, denied;
  logic [2:0]  need, prot, keep;

  assign shamt   = rem_q - {1'b0, nls_q};
  assign idx     = (va_q >> shamt) & ((64'd1 << nls_q) - 64'd1);
  assign cfg_bad = (nls_q < 5'd5) || ({1'b0, nls_q} > rem_q) ||
                   (lvl_q == LVL_W'(MAX_LEVELS));

  assign pmask  = (64'd1 << rem_q) - 64'd1;
  assign rpn    = {8'd0, entry_q[55:12], 12'd0};
  assign pa     = PA_W'((rpn & ~pmask) | (va_q & pmask));
  assign guard  = (entry_q[5:4] == 2'b11) && (acc_q == 2'd2);
  assign prot   = (entry_q[3] && user_q) ? 3'b000 : entry_q[2:0];
  assign denied = |(need & ~prot);
  assign keep   = (acc_q == 2'd1) ? 3'b111 : 3'b101;
  assign new_e  = entry_q | 64'h100 | ((acc_q == 2'd1) ? 64'h80 : 64'h0);

  always_comb begin
    case (acc_q)
      2'd1:    need = 3'b010;
      2'd2:    need = 3'b001;
      default: need = 3'b100;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      va_q <= '0; base_q <= '0; ent_addr_q <= '0; entry_q <= '0; wdata_q <= '0;
      nls_q <= '0; rem_q <= '0; page_q <= '0; acc_q <= '0; user_q <= 1'b0;
      lvl_q <= '0; fault_q <= F_NONE; perm_q <= '0; paddr_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr; base_q <= req_root_base; nls_q <= req_root_nls;
          rem_q <= req_space_bits; acc_q <= req_access; user_q <= req_user;
          lvl_q <= '0; fault_q <= F_NONE; perm_q <= '0; paddr_q <= '0; page_q <= '0;
          state <= S_LEVEL;
        end
        S_LEVEL: begin
          if (cfg_bad) begin
            fault_q <= F_CFG;
            state <= S_FIN;
          end else begin
            ent_addr_q <= base_q + (idx << 3);
            state <= S_READ;
          end
        end
        S_READ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          entry_q <= mem_rsp_data;
          rem_q <= rem_q - {1'b0, nls_q};
          lvl_q <= lvl_q + 1'b1;
          state <= S_EVAL;
        end
        S_EVAL: begin
          if (!entry_q[63]) begin
            fault_q <= F_NOPTE;
            state <= S_FIN;
          end else if (entry_q[62]) begin
            if (guard) begin
              fault_q <= F_GUARD;
              state <= S_FIN;
            end else if (denied) begin
              fault_q <= F_PROT;
              state <= S_FIN;
            end else begin
              paddr_q <= pa;
              page_q <= rem_q;
              perm_q <= prot & keep;
              wdata_q <= new_e;
              state <= (new_e != entry_q) ? S_WB : S_FIN;
            end
          end else begin
            base_q <= {8'd0, entry_q[55:8], 8'd0};
            nls_q <= entry_q[4:0];
            state <= S_LEVEL;
          end
        end
        S_WB: if (mem_req_ready) state <= S_FIN;
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == S_IDLE);
  assign mem_req_valid  = (state == S_READ) || (state == S_WB);
  assign mem_req_write  = (state == S_WB);
  assign mem_req_addr   = ent_addr_q;
  assign mem_req_wdata  = wdata_q;
  assign done           = (state == S_FIN);
  assign done_fault     = fault_q;
  assign done_paddr     = paddr_q;
  assign done_page_bits = page_q;
  assign done_perm      = perm_q;

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[8]);

  // R9
  wb_changed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata != entry_q);

  // R10
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> lvl_q < LVL_W'(MAX_LEVELS));

  // R8
  no_write_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault == F_NONE && acc_q != 2'd1 |-> !done_perm[1]);
endmodule

// File: tb/tb_radix_walker.sv
module tb_radix_walker;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 56;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_user = 1'b0;
  logic [63:0] req_vaddr = '0, req_root_base = '0;
  logic [4:0] req_root_nls = '0;
  logic [5:0] req_space_bits = '0;
  logic [1:0] req_access = '0;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [63:0] mem_req_addr, mem_req_wdata, mem_rsp_data;
  logic done;
  logic [2:0] done_fault, done_perm;
  logic [PA_W-1:0] done_paddr;
  logic [5:0] done_page_bits;

  radix_walker #(.MAX_LEVELS(8), .PA_W(PA_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] mem [0:4095];
  int n_chk = 0, n_bad = 0, reads = 0, writes = 0;
  logic [63:0] last_waddr, last_wdata, rd_addr;
  logic [31:0] seed = 32'd7;
  int wait_n = 0, cnt = 0;
  bit pend = 0, finished = 0;
  logic [2:0] r_fault, r_perm;
  logic [PA_W-1:0] r_paddr;
  logic [5:0] r_page;

  // variable-latency memory responder (R11)
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mem[rd_addr[14:3]]; pend = 0;
        end else cnt--;
      end else if (mem_req_valid) begin
        if (wait_n > 0) wait_n--;
        else begin
          mem_req_ready = 1'b1;
          seed = seed * 32'd1103515245 + 32'd12345;
          wait_n = int'(seed[17:16]) % 3;
          if (mem_req_write) begin
            writes++; last_waddr = mem_req_addr; last_wdata = mem_req_wdata;
            mem[mem_req_addr[14:3]] = mem_req_wdata;
          end else begin
            reads++; rd_addr = mem_req_addr; pend = 1; cnt = int'(seed[21:20]);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic [63:0] base, input logic [4:0] nls,
                      input logic [5:0] sb, input logic [1:0] acc, input logic usr);
    int n;
    @(negedge clk);
    req_vaddr = va; req_root_base = base; req_root_nls = nls; req_space_bits = sb;
    req_access = acc; req_user = usr; req_valid = 1'b1; reads = 0; writes = 0;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk("R12 done seen", {63'd0, done}, 64'd1);
    r_fault = done_fault; r_perm = done_perm; r_paddr = done_paddr; r_page = done_page_bits;
    @(negedge clk);
    chk("R12 done pulse", {63'd0, done}, 64'd0);
  endtask

  function automatic logic [63:0] leaf(input logic [43:0] pn, input logic rf, input logic ch,
                                       input logic [1:0] att, input logic pv, input logic [2:0] rwx);
    return 64'hC000_0000_0000_0000 | ({20'd0, pn} << 12) | (64'(rf) << 8) | (64'(ch) << 7) |
           (64'(att) << 4) | (64'(pv) << 3) | 64'(rwx);
  endfunction

  function automatic logic [63:0] ptr(input logic [63:0] b, input logic [4:0] n);
    return 64'h8000_0000_0000_0000 | (b & 64'h00FF_FFFF_FFFF_FF00) | 64'(n);
  endfunction

  initial begin
    int wd = 0;
    while (!finished && wd < 150000) begin @(posedge clk); wd++; end
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {63'd0, req_ready}, 64'd1);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 memvalid", {63'd0, mem_req_valid}, 64'd0);

    // two-level tree: root 0x1000, tables at 0x2000 + i*0x100
    for (int i = 0; i < 32; i++) begin
      mem[(64'h1000 >> 3) + i] = ptr(64'h2000 + 64'(i) * 64'h100, 5'd5);
      for (int j = 0; j < 32; j++)
        mem[((64'h2000 + 64'(i) * 64'h100) >> 3) + j] = leaf(44'(i * 32 + j + 1), 1, 1, 2'b00, 0, 3'b111);
    end
    for (int k = 0; k < 64; k++) begin
      logic [63:0] va;
      int i, j, off;
      i = k % 32; j = (k * 7) % 32; off = (k * 37) & 16'h7FF;
      va = (64'(k) << 40) | (64'(i) << 16) | (64'(j) << 11) | 64'(off);
      walk(va, 64'h1000, 5'd5, 6'd21, 2'(k % 3), k[0]);
      chk("R5 fault", 64'(r_fault), 64'd0);
      chk("R6 paddr", 64'(r_paddr), (64'(i * 32 + j + 1) << 12) | 64'(off));
      chk("R6 page", 64'(r_page), 64'd11);
      chk("R8 perm", 64'(r_perm), (k % 3 == 1) ? 64'd7 : 64'd5);
      chk("R3 R11 reads", 64'(reads), 64'd2);
      chk("R9 no wb", 64'(writes), 64'd0);
    end

    // R2 bad exponents
    walk(64'h0, 64'h1000, 5'd4, 6'd21, 2'd0, 0);
    chk("R2 small nls", 64'(r_fault), 64'd1); chk("R2 no read", 64'(reads), 64'd0);
    walk(64'h0, 64'h1000, 5'd5, 6'd4, 2'd0, 0);
    chk("R2 nls>size", 64'(r_fault), 64'd1); chk("R2 no read b", 64'(reads), 64'd0);
    mem[(64'h1000 >> 3) + 31] = ptr(64'h2000 + 31 * 64'h100, 5'd3);
    walk(64'd31 << 16, 64'h1000, 5'd5, 6'd21, 2'd0, 0);
    chk("R2 child nls", 64'(r_fault), 64'd1); chk("R2 one read", 64'(reads), 64'd1);

    // R4 invalid entries
    mem[64'h2000 >> 3] = 64'h4000_0000_0000_1007;
    walk(64'h0, 64'h1000, 5'd5, 6'd21, 2'd0, 0);
    chk("R4 leaf invalid", 64'(r_fault), 64'd2); chk("R4 reads", 64'(reads), 64'd2);
    mem[(64'h1000 >> 3) + 30] = 64'h0;
    walk(64'd30 << 16, 64'h1000, 5'd5, 6'd21, 2'd0, 0);
    chk("R4 root invalid", 64'(r_fault), 64'd2); chk("R4 reads b", 64'(reads), 64'd1);

    // R6 leaf at root level
    mem[(64'h0800 >> 3) + 3] = leaf(44'h12345, 1, 1, 2'b00, 0, 3'b111);
    walk((64'd3 << 16) | 64'hABCD, 64'h0800, 5'd5, 6'd21, 2'd1, 0);
    chk("R6 big paddr", 64'(r_paddr), 64'h1234ABCD);
    chk("R6 big page", 64'(r_page), 64'd16);

    // R7 R8 R9 protection grid on entry 5 of 0x0800
    for (int p = 0; p < 8; p++)
      for (int pv = 0; pv < 2; pv++)
        for (int at = 0; at < 2; at++)
          for (int ac = 0; ac < 3; ac++)
            for (int us = 0; us < 2; us++) begin
              logic [63:0] e;
              logic [2:0] g, nd, ef;
              e = leaf(44'h40, 0, 0, at ? 2'b11 : 2'b00, pv[0], 3'(p));
              mem[(64'h0800 >> 3) + 5] = e;
              walk((64'd5 << 16) | 64'h10, 64'h0800, 5'd5, 6'd21, 2'(ac), us[0]);
              g = (pv == 1 && us == 1) ? 3'b000 : 3'(p);
              nd = (ac == 1) ? 3'b010 : (ac == 2) ? 3'b001 : 3'b100;
              ef = (at == 1 && ac == 2) ? 3'd4 : ((nd & ~g) != 0) ? 3'd3 : 3'd0;
              chk("R7 fault", 64'(r_fault), 64'(ef));
              if (ef == 0) begin
                chk("R8 perm", 64'(r_perm), 64'(g & ((ac == 1) ? 3'b111 : 3'b101)));
                chk("R9 wb count", 64'(writes), 64'd1);
                chk("R9 wb addr", last_waddr, 64'h0828);
                chk("R8 wb data", last_wdata, e | 64'h100 | ((ac == 1) ? 64'h80 : 64'h0));
              end else chk("R9 fault no wb", 64'(writes), 64'd0);
            end

    // R9 suppression when unchanged
    mem[(64'h0800 >> 3) + 6] = leaf(44'h41, 1, 1, 2'b00, 0, 3'b111);
    walk(64'd6 << 16, 64'h0800, 5'd5, 6'd21, 2'd1, 0);
    chk("R9 rc set write", 64'(writes), 64'd0);
    mem[(64'h0800 >> 3) + 7] = leaf(44'h42, 1, 0, 2'b00, 0, 3'b111);
    walk(64'd7 << 16, 64'h0800, 5'd5, 6'd21, 2'd0, 0);
    chk("R9 ref set read", 64'(writes), 64'd0);
    walk(64'd7 << 16, 64'h0800, 5'd5, 6'd21, 2'd1, 0);
    chk("R9 chg write", 64'(writes), 64'd1);
    chk("R8 chg data", last_wdata, leaf(44'h42, 1, 1, 2'b00, 0, 3'b111));

    // R10 level limit with a self-referencing directory
    for (int i = 0; i < 32; i++) mem[(64'h0400 >> 3) + i] = ptr(64'h0400, 5'd5);
    walk(64'h0, 64'h0400, 5'd5, 6'd63, 2'd0, 0);
    chk("R10 limit fault", 64'(r_fault), 64'd1);
    chk("R10 limit reads", 64'(reads), 64'd8);
    mem[(64'h0400 >> 3) + 1] = leaf(44'h1234, 1, 1, 2'b00, 0, 3'b111);
    walk(64'h800055, 64'h0400, 5'd5, 6'd63, 2'd0, 0);
    chk("R10 deep fault", 64'(r_fault), 64'd0);
    chk("R10 deep reads", 64'(reads), 64'd8);
    chk("R3 deep page", 64'(r_page), 64'd23);
    chk("R6 deep paddr", 64'(r_paddr), 64'h1000055);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule